// File: doc/BRIEF.md
# Dual condition-code compare unit

This block carries out the compare step of a vector shader. Each compare instruction provides the x and y components of two source operands, plus one 3-bit relation code for each of those two lanes. When the execute strobe is high, each lane compares its pair of components under its own relation. The result is written into that lane's condition flag. The flags hold their values between instructions, so conditional branches that come later can read them.

Operands use a 24-bit float encoding: sign in bit 23, a 7-bit exponent in bits 22:16 and a 16-bit mantissa in bits 15:0. Values are ordered as sign-magnitude numbers. The z and w components are never presented to the block. A vertex-start strobe clears both flags before each new program runs.

Top module: `ccmp_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, both `cc_x` and `cc_y` read 0.
- R2: When `exec` is high, `cc_x` takes the result of comparing `src1_x` with `src2_x` under `rel_x`, on the clock edge where `exec` is sampled.
- R3: The y lane works independently of the x lane. When `exec` is high, `cc_y` takes the result of `src1_y` compared with `src2_y` under `rel_y`, even if `rel_x` selects a different relation.
- R4: The relation codes are 0 for equal, 1 for not equal, 2 for less than, 3 for less or equal, 4 for greater than and 5 for greater or equal. In each case the relation is read as src1 REL src2.
- R5: Relation codes 6 and 7 are unknown. A lane whose code is unknown keeps its previous flag value, even when `exec` is high.
- R6: When `vtx_clear` is high, both flags are 0 after the next clock edge.
- R7: If `vtx_clear` and `exec` are high in the same cycle, the clear takes priority and both flags become 0.
- R8: While `exec` and `vtx_clear` are both low, the flags hold their values, whatever the operand and relation inputs do.
- R9: Operands are ordered by sign and magnitude. Every negative nonzero value is below every positive nonzero value. Between two negative values, the one with the larger magnitude is the smaller value.
- R10: Positive zero (0x000000) and negative zero (0x800000) compare as equal, and neither one is less than the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vtx_clear | input | 1 | Clear both flags at vertex start |
| exec | input | 1 | Execute a compare instruction |
| src1_x | input | 24 | First operand, x component |
| src2_x | input | 24 | Second operand, x component |
| src1_y | input | 24 | First operand, y component |
| src2_y | input | 24 | Second operand, y component |
| rel_x | input | 3 | Relation code for the x lane |
| rel_y | input | 3 | Relation code for the y lane |
| cc_x | output | 1 | Condition flag driven by the x lane |
| cc_y | output | 1 | Condition flag driven by the y lane |

## Verification
A compare and a vertex-start clear can both arrive in the same cycle. To provoke this, the bench first sets both flags to 1. It then raises `exec` together with `vtx_clear`, using operands and relations that would make both lanes true. The outcome is judged on the flags one edge later, and both must read 0. A separate step raises `exec` alone with unknown relation codes, to show that the flags keep their values.

// File: rtl/ccmp_pkg.sv
package ccmp_pkg;
    localparam int unsigned REL_W = 3;

    typedef enum logic [REL_W-1:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5
    } rel_e;
endpackage

// File: rtl/ccmp_order.sv
module ccmp_order #(
    parameter int unsigned VAL_W = 24
) (
    input  logic [VAL_W-1:0] a,
    input  logic [VAL_W-1:0] b,
    output logic             eq,
    output logic             lt
);
    localparam int unsigned MAG_W = VAL_W - 1;

    logic [MAG_W-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b, both_zero;

    assign mag_a     = a[MAG_W-1:0];
    assign mag_b     = b[MAG_W-1:0];
    assign sgn_a     = a[VAL_W-1];
    assign sgn_b     = b[VAL_W-1];
    assign both_zero = (mag_a == '0) && (mag_b == '0);

    always_comb begin
        if (both_zero) begin
            eq = 1'b1;
            lt = 1'b0;
        end else if (sgn_a != sgn_b) begin
            eq = 1'b0;
            lt = sgn_a;
        end else begin
            eq = (mag_a == mag_b);
            lt = sgn_a ? (mag_a > mag_b) : (mag_a < mag_b);
        end
    end

    // R10
    always_comb begin
        if (both_zero) begin
            signed_zero_chk: assert (eq && !lt);
        end
    end
endmodule

// File: rtl/ccmp_lane.sv
module ccmp_lane
    import ccmp_pkg::*;
#(
    parameter int unsigned VAL_W = 24
) (
    input  logic [VAL_W-1:0] a,
    input  logic [VAL_W-1:0] b,
    input  logic [REL_W-1:0] rel,
    output logic             hit,
    output logic             known
);
    logic eq, lt;

    ccmp_order #(.VAL_W(VAL_W)) u_order (
        .a  (a),
        .b  (b),
        .eq (eq),
        .lt (lt)
    );

    always_comb begin
        known = 1'b1;
        hit   = 1'b0;
        case (rel)
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt || eq;
            REL_GT:  hit = !lt && !eq;
            REL_GE:  hit = !lt;
            default: known = 1'b0;
        endcase
    end

    // R4: no relation pair may disagree with the ordering it is built on
    always_comb begin
        if (known && (rel == REL_LT) && eq) begin
            lt_excludes_eq_chk: assert (!hit);
        end
    end
endmodule

// File: rtl/ccmp_unit.sv
module ccmp_unit
    import ccmp_pkg::*;
#(
    parameter int unsigned VAL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vtx_clear,
    input  logic             exec,
    input  logic [VAL_W-1:0] src1_x,
    input  logic [VAL_W-1:0] src2_x,
    input  logic [VAL_W-1:0] src1_y,
    input  logic [VAL_W-1:0] src2_y,
    input  logic [REL_W-1:0] rel_x,
    input  logic [REL_W-1:0] rel_y,
    output logic             cc_x,
    output logic             cc_y
);
    localparam int unsigned LANES = 2;

    typedef struct packed {
        logic [LANES-1:0] cc;
    } state_t;

    state_t st_d, st_q;

    logic [VAL_W-1:0] lane_a   [LANES];
    logic [VAL_W-1:0] lane_b   [LANES];
    logic [REL_W-1:0] lane_rel [LANES];
    logic [LANES-1:0] lane_hit, lane_known;

    assign lane_a[0]   = src1_x;
    assign lane_b[0]   = src2_x;
    assign lane_rel[0] = rel_x;
    assign lane_a[1]   = src1_y;
    assign lane_b[1]   = src2_y;
    assign lane_rel[1] = rel_y;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ccmp_lane #(.VAL_W(VAL_W)) u_lane (
            .a     (lane_a[g]),
            .b     (lane_b[g]),
            .rel   (lane_rel[g]),
            .hit   (lane_hit[g]),
            .known (lane_known[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (vtx_clear) begin
            st_d.cc = '0;
        end else if (exec) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_known[i]) st_d.cc[i] = lane_hit[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_x = st_q.cc[0];
    assign cc_y = st_q.cc[1];

    // R6 R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_clear |=> (!cc_x && !cc_y));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vtx_clear && !exec) |=> $stable({cc_x, cc_y}));

    // R5
    unknown_x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !vtx_clear && rel_x > 3'd5) |=> $stable(cc_x));

    // R5
    unknown_y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !vtx_clear && rel_y > 3'd5) |=> $stable(cc_y));
endmodule

// File: tb/tb_ccmp_unit.sv
`timescale 1ns/1ps
module tb_ccmp_unit;
    localparam int VW    = 24;
    localparam int VEC_W = 3 + 3 + 4*VW + 2;
    localparam int NVEC  = 10;

    // fields: rel_x, rel_y, src1_x, src2_x, src1_y, src2_y, exp_x, exp_y
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {3'd0, 3'd2, 24'h3F0000, 24'h3F0000, 24'h3F0000, 24'h400000, 1'b1, 1'b1},
        {3'd1, 3'd5, 24'h3F0000, 24'h400000, 24'h3F0000, 24'h400000, 1'b1, 1'b0},
        {3'd4, 3'd3, 24'h400000, 24'h3F0000, 24'h400000, 24'h400000, 1'b1, 1'b1},
        {3'd2, 3'd4, 24'hC00000, 24'hBF0000, 24'hBF0000, 24'h3F0000, 1'b1, 1'b0},
        {3'd0, 3'd1, 24'h000000, 24'h800000, 24'h800000, 24'h000000, 1'b1, 1'b0},
        {3'd6, 3'd2, 24'h000000, 24'h3F0000, 24'hBF0000, 24'h000000, 1'b1, 1'b1},
        {3'd5, 3'd7, 24'hC00000, 24'hBF0000, 24'h000000, 24'h000000, 1'b0, 1'b1},
        {3'd3, 3'd2, 24'h800000, 24'h000000, 24'h000000, 24'h800000, 1'b1, 1'b0},
        {3'd4, 3'd0, 24'h3F0000, 24'hC00000, 24'h3F0000, 24'h400000, 1'b1, 1'b0},
        {3'd2, 3'd4, 24'h3F0001, 24'h3F0000, 24'h3F0001, 24'h3F0000, 1'b0, 1'b1}
    };
    localparam string VTAG [NVEC] = '{"R2 R4", "R3 R4", "R3 R4", "R9", "R10",
                                      "R5 R9", "R5 R9", "R10", "R9", "R2 R3"};

    logic clk = 1'b0, rst_n = 1'b0, vtx_clear = 1'b0, exec = 1'b0;
    logic [VW-1:0] src1_x = '0, src2_x = '0, src1_y = '0, src2_y = '0;
    logic [2:0] rel_x = '0, rel_y = '0;
    logic cc_x, cc_y;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccmp_unit dut (
        .clk(clk), .rst_n(rst_n), .vtx_clear(vtx_clear), .exec(exec),
        .src1_x(src1_x), .src2_x(src2_x), .src1_y(src1_y), .src2_y(src2_y),
        .rel_x(rel_x), .rel_y(rel_y), .cc_x(cc_x), .cc_y(cc_y)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {cc_y,cc_x} = %b, expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic clr, input logic ex, input logic [2:0] rx, input logic [2:0] ry,
                         input logic [VW-1:0] ax, input logic [VW-1:0] bx,
                         input logic [VW-1:0] ay, input logic [VW-1:0] by);
        @(negedge clk);
        vtx_clear = clr; exec = ex; rel_x = rx; rel_y = ry;
        src1_x = ax; src2_x = bx; src1_y = ay; src2_y = by;
        @(negedge clk);
        vtx_clear = 1'b0; exec = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: in reset and just after
        #12;
        check("R1 in reset", {cc_y, cc_x}, 2'b00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {cc_y, cc_x}, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            apply(1'b0, 1'b1, v[103:101], v[100:98], v[97:74], v[73:50], v[49:26], v[25:2]);
            check(VTAG[i], {cc_y, cc_x}, {v[0], v[1]});
        end
        // last vector leaves {y,x} = 2'b10

        // R8: inputs wiggle while idle
        apply(1'b0, 1'b0, 3'd0, 3'd0, 24'h3F0000, 24'h3F0000, 24'h3F0000, 24'h3F0000);
        check("R8 idle hold", {cc_y, cc_x}, 2'b10);

        // R6: clear alone
        apply(1'b1, 1'b0, 3'd0, 3'd0, 24'h0, 24'h0, 24'h0, 24'h0);
        check("R6 clear", {cc_y, cc_x}, 2'b00);

        // R5: both lanes unknown after setting both flags
        apply(1'b0, 1'b1, 3'd5, 3'd5, 24'h400000, 24'h3F0000, 24'h3F0000, 24'h3F0000);
        check("R4 set both", {cc_y, cc_x}, 2'b11);
        apply(1'b0, 1'b1, 3'd7, 3'd6, 24'h3F0000, 24'h400000, 24'h3F0000, 24'h400000);
        check("R5 unknown both", {cc_y, cc_x}, 2'b11);

        // R7: clear and exec together, compare would be true
        apply(1'b1, 1'b1, 3'd0, 3'd3, 24'h3F0000, 24'h3F0000, 24'h3F0000, 24'h400000);
        check("R7 clear over exec", {cc_y, cc_x}, 2'b00);

        // R1: reset mid-run
        apply(1'b0, 1'b1, 3'd1, 3'd1, 24'h3F0000, 24'h0, 24'h3F0000, 24'h0);
        check("R3 set before reset", {cc_y, cc_x}, 2'b11);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 async reset", {cc_y, cc_x}, 2'b00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule